// File: doc/BRIEF.md
# Floating-Point Comparison Unit

This block compares two IEEE-754 operands and returns the outcome as an integer 0 or 1, one clock after the request. A format input picks between single and double precision. In single precision only the low 32 bits of each 64-bit operand word are read. A 3-bit operation code picks the relation: less-or-equal, less-than or equality.

Each result comes with a one-cycle invalid-operation pulse. The same condition is ORed into a sticky flag that only reset clears. Ordering follows sign-magnitude rules, so infinities and subnormals take their natural places and the two zeros count as equal. The two ordering relations treat any NaN as invalid. Equality raises invalid only for a signaling NaN.

A two-state machine tracks the output side. The state `ST_IDLE` moves to `ST_EMIT` when `req_valid` is high. `ST_EMIT` stays in `ST_EMIT` when another request follows at once, and returns to `ST_IDLE` when none does. `rsp_valid` is high exactly in `ST_EMIT`.

Top module: `fp_compare_unit`

## Requirements
- R1: Operation code 0 gives less-or-equal (a <= b), 1 gives less-than (a < b) and 2 gives equality (a == b). The result bit is `rsp_data[0]`: 1 when the relation holds, 0 otherwise. `rsp_data[63:1]` is always 0.
- R2: When `req_dbl` is 1 the operands are 64-bit doubles. When it is 0 they are singles taken from bits [31:0], and bits [63:32] have no effect on any output.
- R3: Ordered operands compare by value: negatives sit below positives, two negatives compare with their magnitudes reversed, and infinities and subnormals keep their real order.
- R4: +0 and -0 are equal: equality gives 1, less-than gives 0 and less-or-equal gives 1.
- R5: For less-or-equal and less-than, if either operand is a NaN (exponent all ones, fraction nonzero) of either kind, the result is 0 and the invalid pulse is raised.
- R6: For equality, any NaN operand gives result 0. Invalid is raised only when an operand is a signaling NaN, meaning the top fraction bit is 0. A quiet NaN raises nothing.
- R7: Operation codes 3 to 7 give result 0 and no invalid pulse.
- R8: `rsp_data`, `rsp_invalid` and `rsp_valid` update on the clock edge after the one that samples `req_valid`. `rsp_valid` is low in any cycle that follows no request, and `rsp_invalid` is only ever high together with `rsp_valid`.
- R9: `flag_invalid` is the OR of every invalid pulse since reset. A compare never clears it.
- R10: After reset, `rsp_valid`, `rsp_invalid`, `rsp_data` and `flag_invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_dbl | input | 1 | 1 = double, 0 = single |
| req_op | input | 3 | Relation select |
| req_a | input | 64 | Left operand word |
| req_b | input | 64 | Right operand word |
| rsp_data | output | 64 | Integer result, 0 or 1 |
| rsp_invalid | output | 1 | Invalid-operation pulse for this result |
| rsp_valid | output | 1 | Result strobe |
| flag_invalid | output | 1 | Sticky invalid flag |

## Verification
The bench sweeps every pair from a set of twelve operands in both formats, under all three relations. The set holds both zeros, values of both signs, both infinities, a quiet NaN, a signaling NaN, the smallest subnormal and the most negative finite value. Expected results come from real-number ordering in the bench.

Each likely fault shows up in this sweep. A design that compares raw bits would order the negatives backwards or report -0 below +0. One that confuses the two NaN kinds would raise invalid on a quiet-NaN equality, or would miss it on an ordering compare. One that reads the upper word in single mode would be thrown off by the junk the bench places there. The bench also drives the reserved codes and checks the sticky flag across the run.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int WORD_W = 64;
    localparam int MAG_W  = WORD_W - 1;
    localparam int OP_W   = 3;

    localparam logic [OP_W-1:0] OP_LE = 3'd0;
    localparam logic [OP_W-1:0] OP_LT = 3'd1;
    localparam logic [OP_W-1:0] OP_EQ = 3'd2;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } opnd_t;

    typedef enum logic {ST_IDLE, ST_EMIT} state_e;
endpackage

// File: rtl/fpc_unpack.sv
module fpc_unpack
    import fpc_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] word,
    output opnd_t                info
);
    localparam int TOP = EXP_W + MAN_W;

    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] frac;

    always_comb begin
        expo      = word[TOP-1:MAN_W];
        frac      = word[MAN_W-1:0];
        info.sign = word[TOP];
        info.nan  = (&expo) && (|frac);
        info.snan = info.nan && !frac[MAN_W-1];
        info.zero = (word[TOP-1:0] == '0);
        info.mag  = MAG_W'(word[TOP-1:0]);
    end
endmodule

// File: rtl/fpc_relate.sv
module fpc_relate
    import fpc_pkg::*;
(
    input  opnd_t           a,
    input  opnd_t           b,
    input  logic [OP_W-1:0] op,
    output logic            hit,
    output logic            inv
);
    logic any_nan, any_snan, both_zero, eq_v, lt_v;

    always_comb begin
        any_nan   = a.nan || b.nan;
        any_snan  = a.snan || b.snan;
        both_zero = a.zero && b.zero;
        eq_v      = !any_nan && (both_zero || (a.sign == b.sign && a.mag == b.mag));
        if (any_nan || both_zero)
            lt_v = 1'b0;
        else if (a.sign != b.sign)
            lt_v = a.sign;
        else if (!a.sign)
            lt_v = a.mag < b.mag;
        else
            lt_v = a.mag > b.mag;

        unique case (op)
            OP_LE: begin hit = lt_v || eq_v; inv = any_nan;  end
            OP_LT: begin hit = lt_v;         inv = any_nan;  end
            OP_EQ: begin hit = eq_v;         inv = any_snan; end
            default: begin hit = 1'b0;       inv = 1'b0;     end
        endcase
    end
endmodule

// File: rtl/fp_compare_unit.sv
module fp_compare_unit
    import fpc_pkg::*;
#(
    parameter int SP_EXP = 8,
    parameter int SP_MAN = 23,
    parameter int DP_EXP = 11,
    parameter int DP_MAN = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_dbl,
    input  logic [OP_W-1:0]   req_op,
    input  logic [WORD_W-1:0] req_a,
    input  logic [WORD_W-1:0] req_b,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_invalid,
    output logic              rsp_valid,
    output logic              flag_invalid
);
    localparam int SP_W = SP_EXP + SP_MAN + 1;
    localparam int DP_W = DP_EXP + DP_MAN + 1;

    logic [WORD_W-1:0] words [2];
    opnd_t             sel   [2];
    logic              hit, inv;
    state_e            state, state_nx;

    assign words[0] = req_a;
    assign words[1] = req_b;

    for (genvar i = 0; i < 2; i++) begin : g_opnd
        opnd_t sp_info, dp_info;
        fpc_unpack #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_sp (
            .word(words[i][SP_W-1:0]), .info(sp_info));
        fpc_unpack #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_dp (
            .word(words[i][DP_W-1:0]), .info(dp_info));
        assign sel[i] = req_dbl ? dp_info : sp_info;
    end

    fpc_relate u_rel (.a(sel[0]), .b(sel[1]), .op(req_op), .hit(hit), .inv(inv));

    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = req_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_nx = req_valid ? ST_EMIT : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data     <= '0;
            rsp_invalid  <= 1'b0;
            flag_invalid <= 1'b0;
        end else if (req_valid) begin
            rsp_data     <= WORD_W'(hit);
            rsp_invalid  <= inv;
            flag_invalid <= flag_invalid | inv;
        end else begin
            rsp_invalid  <= 1'b0;
        end
    end

    assign rsp_valid = (state == ST_EMIT);
endmodule

// File: rtl/fpc_checks.sv
module fpc_checks
    import fpc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [OP_W-1:0]   req_op,
    input logic [WORD_W-1:0] rsp_data,
    input logic              rsp_invalid,
    input logic              rsp_valid,
    input logic              flag_invalid
);
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r8_flag_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_invalid |-> rsp_valid);
    a_r1_result_binary: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_data[WORD_W-1:1] == '0);
    a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        flag_invalid |=> flag_invalid);
    a_r9_sticky_catches: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_invalid |-> flag_invalid);
    a_r7_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op > OP_EQ) |=> (!rsp_invalid && rsp_data == '0));
endmodule

bind fp_compare_unit fpc_checks u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .rsp_data(rsp_data), .rsp_invalid(rsp_invalid), .rsp_valid(rsp_valid),
    .flag_invalid(flag_invalid));

// File: tb/sim_fp_compare_unit.sv
module sim_fp_compare_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_dbl = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [63:0] req_a = '0;
    logic [63:0] req_b = '0;
    logic [63:0] rsp_data;
    logic        rsp_invalid, rsp_valid, flag_invalid;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit exp_sticky = 0;

    always #5 clk = ~clk;

    fp_compare_unit u0 (.*);

    localparam int NV = 12;

    function automatic logic [63:0] vbits(int i, bit dbl);
        logic [31:0] s;
        logic [63:0] d;
        case (i)
            0:  begin s = 32'h0000_0000; d = 64'h0000_0000_0000_0000; end
            1:  begin s = 32'h8000_0000; d = 64'h8000_0000_0000_0000; end
            2:  begin s = 32'h3F80_0000; d = 64'h3FF0_0000_0000_0000; end
            3:  begin s = 32'hBF80_0000; d = 64'hBFF0_0000_0000_0000; end
            4:  begin s = 32'h4020_0000; d = 64'h4004_0000_0000_0000; end
            5:  begin s = 32'hC020_0000; d = 64'hC004_0000_0000_0000; end
            6:  begin s = 32'h7F80_0000; d = 64'h7FF0_0000_0000_0000; end
            7:  begin s = 32'hFF80_0000; d = 64'hFFF0_0000_0000_0000; end
            8:  begin s = 32'h7FC0_0000; d = 64'h7FF8_0000_0000_0000; end
            9:  begin s = 32'h7F80_0001; d = 64'h7FF0_0000_0000_0001; end
            10: begin s = 32'h0000_0001; d = 64'h0000_0000_0000_0001; end
            default: begin s = 32'hFF7F_FFFF; d = 64'hFFEF_FFFF_FFFF_FFFF; end
        endcase
        // R2: junk in the upper word must not matter in single mode
        return dbl ? d : {32'hDEAD_BEEF, s};
    endfunction

    function automatic real vreal(int i);
        case (i)
            0, 1: return 0.0;
            2: return 1.0;   3: return -1.0;
            4: return 2.5;   5: return -2.5;
            6: return 1.0e300; 7: return -1.0e300;
            10: return 1.0e-300;
            11: return -1.0e200;
            default: return 0.0;
        endcase
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_one(int ia, int ib, int op, bit dbl);
        bit anan, snan, r, inv;
        real x, y;
        string tag;
        req_valid = 1'b1; req_dbl = dbl; req_op = 3'(op);
        req_a = vbits(ia, dbl); req_b = vbits(ib, dbl);
        anan = (ia == 8 || ia == 9 || ib == 8 || ib == 9);
        snan = (ia == 9 || ib == 9);
        x = vreal(ia); y = vreal(ib);
        case (op)
            0: begin r = !anan && (x <= y); inv = anan; end
            1: begin r = !anan && (x <  y); inv = anan; end
            2: begin r = !anan && (x == y); inv = snan; end
            default: begin r = 0; inv = 0; end
        endcase
        exp_sticky = exp_sticky | inv;
        if (op > 2) tag = "R7";
        else if (anan) tag = (op == 2) ? "R6" : "R5";
        else if (ia <= 1 && ib <= 1) tag = "R4";
        else tag = dbl ? "R3" : "R2/R3";
        @(negedge clk);
        chk({tag, " R1 result"}, rsp_data, {63'd0, r});
        chk({tag, " invalid"}, {63'd0, rsp_invalid}, {63'd0, inv});
        chk("R8 valid", {63'd0, rsp_valid}, 64'd1);
        chk("R9 sticky", {63'd0, flag_invalid}, {63'd0, exp_sticky});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 valid", {63'd0, rsp_valid}, 64'd0);
        chk("R10 data", rsp_data, 64'd0);
        chk("R10 sticky", {63'd0, flag_invalid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 idle", {63'd0, rsp_valid}, 64'd0);
        // R6: quiet NaN equality first, sticky must stay clear
        run_one(8, 2, 2, 1'b0);
        chk("R6 sticky clear", {63'd0, flag_invalid}, 64'd0);
        for (int d = 0; d < 2; d++)
            for (int op = 0; op < 3; op++)
                for (int a = 0; a < NV; a++)
                    for (int b = 0; b < NV; b++)
                        run_one(a, b, op, d[0]);
        for (int op = 3; op < 8; op++) begin
            run_one(0, 0, op, 1'b1);
            run_one(9, 2, op, 1'b0);
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk("R8 drop", {63'd0, rsp_valid}, 64'd0);
        chk("R8 no pulse", {63'd0, rsp_invalid}, 64'd0);
        chk("R9 held", {63'd0, flag_invalid}, 64'd1);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule